// File: doc/BRIEF.md
# DMA Transfer Request Queue Controller

This block is the software-facing front end of a single-channel DMA engine. Software reaches it through a 32-bit register port. It programs a transfer's X and Y byte counts and its flags, then commits the request by writing the start register. Each committed request takes the next hardware transfer ID from a 5-bit counter that wraps from 31 to 0. The request waits in a small queue and is handed to a data mover over a valid/ready request channel in commit order.

The data mover reports each finished transfer by its ID. The block records finished IDs in a 32-bit completion mask. It raises a maskable interrupt on two events: a request leaving the queue (space has become free) and a transfer completing. When the queue is full, the start register reads back nonzero, so software can tell whether a further commit would be taken. Clearing the enable bit of the control register discards all queued work. Setting the pause bit holds requests back from the data mover.

Top module: `dma_req_queue`

## Requirements
- R1: After reset the queue is empty, `req_valid` and `irq` are 0, the next ID is 0, the completion mask and both pending bits are 0, the interrupt mask reads 3 (both sources masked) and control reads 0.
- R2: The X length (0x418) and Y length (0x41C) registers hold a byte count minus one and read back their lower LEN_W bits (16 by default); bits at and above LEN_W read 0.
- R3: Flags (0x40C) bit 0 is cyclic, bit 1 is last and bit 2 is partial-report. With the default configuration, bit 2 is not implemented and reads back 0, and the request carries the flags as read back.
- R4: Writing 1 in bit 0 of the start register (0x408) commits a request when enabled and not full. The request carries the ID shown at 0x404 at the time of the commit, and that ID then advances by one, wrapping from 31 to 0.
- R5: The start register reads 1 while the queue holds DEPTH (4) requests and 0 otherwise. A commit attempted while the queue is full is ignored and does not advance the ID.
- R6: `req_valid` is high while the queue holds a request and the engine is enabled and not paused. ID, lengths and flags stay stable until `req_ready`, and requests leave in commit order.
- R7: Pending bit 0 (0x84, start-of-transfer) is set in the cycle after each request is accepted by the data mover.
- R8: A completion report with `cpl_valid` and ID n sets bit n of the completion mask (0x428) and pending bit 1 (end-of-transfer).
- R9: Bit n of the completion mask is cleared when ID n is allocated to a new request.
- R10: Writing 1 to a pending bit clears it. `irq` is high when a pending bit is set whose mask bit (0x80) is 0.
- R11: Control (0x400) bit 0 is enable and bit 1 is pause, shown on `eng_enable` and `eng_pause`. A commit while disabled is ignored. A control write with bit 0 clear empties the queue. While paused, `req_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| req_valid | output | 1 | Request available to the data mover |
| req_ready | input | 1 | Data mover takes the request |
| req_id | output | 5 | Transfer ID of the offered request |
| req_flags | output | 3 | Flags of the offered request |
| req_xlen | output | LEN_W | X byte count minus one |
| req_ylen | output | LEN_W | Y byte count minus one |
| cpl_valid | input | 1 | Completion report strobe |
| cpl_id | input | 5 | ID of the completed transfer |
| eng_enable | output | 1 | Control enable bit |
| eng_pause | output | 1 | Control pause bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue with the data mover stalled and then tries one more commit. A design with a wrong full count would either drop a queued request or take the extra one and advance the ID. It runs the ID counter through its wrap and completes an ID before that ID is handed out again. A design that wrapped at the wrong value, or kept stale completion bits, would show a wrong next ID or a completion bit still set. It also commits while disabled and while paused, and aborts with requests still queued. These catch designs that leak requests to the data mover or leave entries behind an abort. Finally it clears pending bits while the interrupt is masked, which exposes inverted mask polarity and write-1-clear errors.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int ID_W    = 5;
  localparam int NUM_IDS = 1 << ID_W;
  localparam int FLAG_W  = 3;

  // register byte offsets
  localparam logic [11:0] OFS_IRQ_MASK = 12'h080;
  localparam logic [11:0] OFS_IRQ_PEND = 12'h084;
  localparam logic [11:0] OFS_CTRL     = 12'h400;
  localparam logic [11:0] OFS_NEXT_ID  = 12'h404;
  localparam logic [11:0] OFS_START    = 12'h408;
  localparam logic [11:0] OFS_FLAGS    = 12'h40C;
  localparam logic [11:0] OFS_XLEN     = 12'h418;
  localparam logic [11:0] OFS_YLEN     = 12'h41C;
  localparam logic [11:0] OFS_DONE     = 12'h428;

  // interrupt source bits
  localparam int IRQ_SOT = 0;
  localparam int IRQ_EOT = 1;
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (push && !pop)      cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign full  = (cnt_q == FULLC);
  assign empty = (cnt_q == '0);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULLC);
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_evt,
  input  logic            wr_mask,
  input  logic            wr_pend,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  logic [NSRC-1:0] mask_d, pend_d;

  always_comb begin
    mask_d = wr_mask ? wdata : mask;
    pend_d = pend;
    if (wr_pend) pend_d = pend_d & ~wdata;
    pend_d = pend_d | set_evt;  // a new event wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
      pend <= '0;
    end else begin
      mask <= mask_d;
      pend <= pend_d;
    end
  end

  assign irq = |(pend & ~mask);

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_chk
      a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[g] |=> pend[g]);
      a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && wdata[g] && !set_evt[g]) |=> !pend[g]);
    end
  endgenerate
endmodule

// File: rtl/dma_req_queue.sv
module dma_req_queue
  import dmaq_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int LEN_W       = 16,
  parameter int ADDR_W      = 12,
  parameter bit HAS_CYCLIC  = 1'b1,
  parameter bit HAS_PARTIAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ID_W-1:0]   req_id,
  output logic [FLAG_W-1:0] req_flags,
  output logic [LEN_W-1:0]  req_xlen,
  output logic [LEN_W-1:0]  req_ylen,
  input  logic              cpl_valid,
  input  logic [ID_W-1:0]   cpl_id,
  output logic              eng_enable,
  output logic              eng_pause,
  output logic              irq
);
  localparam int ENT_W = ID_W + FLAG_W + 2 * LEN_W;
  localparam logic [FLAG_W-1:0] FLAG_IMPL = {HAS_PARTIAL, 1'b1, HAS_CYCLIC};

  // register state
  logic [1:0]         ctrl_q, ctrl_d;
  logic [FLAG_W-1:0]  flags_q, flags_d;
  logic [LEN_W-1:0]   xlen_q, xlen_d, ylen_q, ylen_d;
  logic [ID_W-1:0]    nid_q, nid_d;
  logic [NUM_IDS-1:0] done_q, done_d;

  logic [11:0] a;
  logic wr_ctrl, wr_start, commit, abort, pop, full, empty;
  logic [ENT_W-1:0] ent_in, ent_out;
  logic [1:0] irq_mask, irq_pend;

  assign a        = 12'(cfg_addr);
  assign wr_ctrl  = cfg_wr && (a == OFS_CTRL);
  assign wr_start = cfg_wr && (a == OFS_START) && cfg_wdata[0];
  assign commit   = wr_start && ctrl_q[0] && !full;
  assign abort    = wr_ctrl && !cfg_wdata[0];
  assign pop      = req_valid && req_ready;

  always_comb begin
    ctrl_d  = wr_ctrl ? cfg_wdata[1:0] : ctrl_q;
    flags_d = (cfg_wr && a == OFS_FLAGS) ? (cfg_wdata[FLAG_W-1:0] & FLAG_IMPL) : flags_q;
    xlen_d  = (cfg_wr && a == OFS_XLEN) ? cfg_wdata[LEN_W-1:0] : xlen_q;
    ylen_d  = (cfg_wr && a == OFS_YLEN) ? cfg_wdata[LEN_W-1:0] : ylen_q;
    nid_d   = commit ? nid_q + 1'b1 : nid_q;
    done_d  = done_q;
    if (cpl_valid) done_d[cpl_id] = 1'b1;
    if (commit)    done_d[nid_q]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      xlen_q  <= '0;
      ylen_q  <= '0;
      nid_q   <= '0;
      done_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      flags_q <= flags_d;
      xlen_q  <= xlen_d;
      ylen_q  <= ylen_d;
      nid_q   <= nid_d;
      done_q  <= done_d;
    end
  end

  assign ent_in = {nid_q, flags_q, xlen_q, ylen_q};

  dmaq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (abort),
    .push  (commit),
    .wdata (ent_in),
    .pop   (pop),
    .rdata (ent_out),
    .full  (full),
    .empty (empty)
  );

  assign {req_id, req_flags, req_xlen, req_ylen} = ent_out;
  assign req_valid  = !empty && ctrl_q[0] && !ctrl_q[1];
  assign eng_enable = ctrl_q[0];
  assign eng_pause  = ctrl_q[1];

  dmaq_irq #(.NSRC(2)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt ({cpl_valid, pop}),
    .wr_mask (cfg_wr && a == OFS_IRQ_MASK),
    .wr_pend (cfg_wr && a == OFS_IRQ_PEND),
    .wdata   (cfg_wdata[1:0]),
    .mask    (irq_mask),
    .pend    (irq_pend),
    .irq     (irq)
  );

  always_comb begin
    cfg_rdata = '0;
    case (a)
      OFS_IRQ_MASK: cfg_rdata[1:0]        = irq_mask;
      OFS_IRQ_PEND: cfg_rdata[1:0]        = irq_pend;
      OFS_CTRL:     cfg_rdata[1:0]        = ctrl_q;
      OFS_NEXT_ID:  cfg_rdata[ID_W-1:0]   = nid_q;
      OFS_START:    cfg_rdata[0]          = full;
      OFS_FLAGS:    cfg_rdata[FLAG_W-1:0] = flags_q;
      OFS_XLEN:     cfg_rdata[LEN_W-1:0]  = xlen_q;
      OFS_YLEN:     cfg_rdata[LEN_W-1:0]  = ylen_q;
      OFS_DONE:     cfg_rdata             = done_q;
      default:      cfg_rdata             = '0;
    endcase
  end

  // R4: every commit advances the ID by one
  a_r4_id_step: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> nid_q == $past(nid_q) + 1'b1);
  // R5: a start write on a full queue leaves the ID alone
  a_r5_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && full) |=> $stable(nid_q));
  // R6: an offered request holds until taken
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !wr_ctrl) |=> req_valid && $stable(req_id) && $stable(req_xlen));
  // R8: a completion shows up in the mask
  a_r8_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !(commit && nid_q == cpl_id)) |=> done_q[$past(cpl_id)]);
  // R11: paused or disabled engine offers nothing
  a_r11_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] || !ctrl_q[0]) |-> !req_valid);
endmodule

// File: tb/dma_req_queue_bench.sv
module dma_req_queue_bench;
  localparam int LEN_W = 16;
  localparam int ENT_W = 5 + 3 + 2 * LEN_W;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        req_valid, req_ready;
  logic [4:0]  req_id;
  logic [2:0]  req_flags;
  logic [LEN_W-1:0] req_xlen, req_ylen;
  logic        cpl_valid;
  logic [4:0]  cpl_id;
  logic        eng_enable, eng_pause, irq;

  int checks = 0;
  int errors = 0;
  logic [ENT_W-1:0] sb[$];
  logic [4:0] exp_id;
  logic [31:0] rv;

  always #2.5 clk = ~clk;  // 200 MHz

  dma_req_queue u_dma_req_queue (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_id(req_id), .req_flags(req_flags),
    .req_xlen(req_xlen), .req_ylen(req_ylen), .cpl_valid(cpl_valid),
    .cpl_id(cpl_id), .eng_enable(eng_enable), .eng_pause(eng_pause), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] ad, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] ad, output logic [31:0] d);
    cfg_addr = ad;
    #1;
    d = cfg_rdata;
  endtask

  // driver: program and commit, pushing the expectation when acceptance is expected
  task automatic commit(input logic [15:0] x, input logic [15:0] y,
                        input logic [2:0] f, input bit expect_take);
    wr(12'h418, {16'hDEAD, x});
    wr(12'h41C, {16'h0000, y});
    wr(12'h40C, {29'd0, f});
    if (expect_take) begin
      sb.push_back({exp_id, f & 3'b011, x, y});
      exp_id = exp_id + 1'b1;
    end
    wr(12'h408, 32'd1);
  endtask

  task automatic complete(input logic [4:0] id);
    @(posedge clk); #1;
    cpl_valid = 1'b1; cpl_id = id;
    @(posedge clk); #1;
    cpl_valid = 1'b0;
  endtask

  // monitor: compare each accepted request against the scoreboard head (R6)
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R6: actual id %0d expected no request", req_id);
      end else begin
        if ({req_id, req_flags, req_xlen, req_ylen} !== sb[0]) begin
          errors++;
          $display("FAIL R6: actual %0h expected %0h",
                   {req_id, req_flags, req_xlen, req_ylen}, sb[0]);
        end
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_ready = 1'b0; cpl_valid = 1'b0; cpl_id = '0; exp_id = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 req_valid", {31'd0, req_valid}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(12'h404, rv); chk("R1 next id", rv, 0);
    rd(12'h428, rv); chk("R1 done", rv, 0);
    rd(12'h084, rv); chk("R1 pending", rv, 0);
    rd(12'h080, rv); chk("R1 mask", rv, 3);
    rd(12'h400, rv); chk("R1 ctrl", rv, 0);

    // R2 length registers
    wr(12'h418, 32'hABCD1234); rd(12'h418, rv); chk("R2 xlen", rv, 32'h1234);
    wr(12'h41C, 32'hFFFF0077); rd(12'h41C, rv); chk("R2 ylen", rv, 32'h0077);

    // R3 flags: partial bit not implemented
    wr(12'h40C, 32'h7); rd(12'h40C, rv); chk("R3 flags", rv, 3);

    // R11 commit while disabled is ignored
    commit(16'h10, 16'h1, 3'b000, 1'b0);
    rd(12'h404, rv); chk("R11 disabled commit id", rv, 0);
    chk("R11 disabled valid", {31'd0, req_valid}, 0);

    // enable, fill queue with mover stalled
    wr(12'h400, 32'h1);
    chk("R11 enable out", {31'd0, eng_enable}, 1);
    commit(16'h0100, 16'h0001, 3'b001, 1'b1);
    rd(12'h408, rv); chk("R5 not full", rv, 0);
    commit(16'h0200, 16'h0002, 3'b110, 1'b1);
    commit(16'h0300, 16'h0003, 3'b010, 1'b1);
    commit(16'h0400, 16'h0004, 3'b011, 1'b1);
    rd(12'h404, rv); chk("R4 id after four", rv, 4);
    rd(12'h408, rv); chk("R5 full reads 1", rv, 1);
    repeat (3) @(posedge clk); #1;
    chk("R6 held id", {27'd0, req_id}, 0);
    commit(16'h0500, 16'h0005, 3'b000, 1'b0);
    rd(12'h404, rv); chk("R5 full commit ignored", rv, 4);

    // drain, SOT interrupt
    wr(12'h080, 32'h0);
    req_ready = 1'b1;
    repeat (8) @(posedge clk); #1;
    chk("R6 drained", sb.size(), 0);
    rd(12'h084, rv); chk("R7 sot pending", rv, 1);
    chk("R10 irq on", {31'd0, irq}, 1);
    wr(12'h084, 32'h1);
    rd(12'h084, rv); chk("R10 w1c", rv, 0);
    chk("R10 irq off", {31'd0, irq}, 0);

    // R8 completion, EOT masked
    wr(12'h080, 32'h2);
    complete(5'd2);
    rd(12'h428, rv); chk("R8 done bit", rv, 32'h4);
    rd(12'h084, rv); chk("R8 eot pending", rv, 2);
    chk("R10 masked irq", {31'd0, irq}, 0);
    wr(12'h084, 32'h2);

    // R4 wrap and R9 reallocation
    for (int i = 4; i < 32; i++) commit(16'(i), 16'h0, 3'(i), 1'b1);
    rd(12'h404, rv); chk("R4 wrap to 0", rv, 0);
    commit(16'hA0, 16'h0, 3'b000, 1'b1);
    commit(16'hA1, 16'h0, 3'b000, 1'b1);
    rd(12'h428, rv); chk("R9 bit kept before realloc", rv, 32'h4);
    commit(16'hA2, 16'h0, 3'b000, 1'b1);
    rd(12'h428, rv); chk("R9 bit cleared on realloc", rv, 0);

    // R11 pause holds requests back
    wr(12'h400, 32'h3);
    chk("R11 pause out", {31'd0, eng_pause}, 1);
    commit(16'hB0, 16'h0, 3'b001, 1'b1);
    repeat (3) @(posedge clk); #1;
    chk("R11 paused valid", {31'd0, req_valid}, 0);
    chk("R11 paused pending", sb.size(), 1);
    wr(12'h400, 32'h1);
    repeat (3) @(posedge clk); #1;
    chk("R11 resumed", sb.size(), 0);

    // R11 abort empties queue
    req_ready = 1'b0;
    commit(16'hC0, 16'h0, 3'b000, 1'b1);
    commit(16'hC1, 16'h0, 3'b000, 1'b1);
    wr(12'h400, 32'h0);
    sb.delete();
    chk("R11 abort valid", {31'd0, req_valid}, 0);
    wr(12'h400, 32'h1);
    req_ready = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R11 abort nothing left", {31'd0, req_valid}, 0);
    rd(12'h408, rv); chk("R5 empty after abort", rv, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule